// File: doc/BRIEF.md
# Power State Sequencing Controller

This block is the top-level mode controller of a power management unit. It decides whether the supply rails are off, coming up, running, parked in one of two low-power modes, or held down by an over-temperature shutdown. Its inputs are button events from a separate pushbutton classifier, a handful of control register bits, two GPIO control lines, an input undervoltage flag, an over-temperature flag, and combined power-good and fault flags from the regulators. Per-rail delay sequencing and all analog sensing are handled outside this block.

The controller starts in the off state. Leaving it needs either a long button press or the power-off register bit cleared to 0. A start made with the button also needs the button to be released while the rails are in regulation. A power cycle drops the rails, then holds the start-up state for a fixed number of millisecond ticks before running again. Sleep and deep sleep are requested by a register bit that is combined with a GPIO line through AND or OR, as a mode bit selects. Over-temperature shuts everything down and recovers straight to the running state. Undervoltage overrides every other input.

All outputs are registered and change on the same clock edge as the state. The state code is 0 = off, 1 = start-up, 2 = active, 3 = sleep, 4 = deep sleep, 5 = thermal.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While and after a synchronous reset the state is 0 (off), every rail enable is 0, the active-low reset output is 0 and every pulse output is 0.
- R2: A high `vin_uv` at a clock edge makes the state 0 after that edge, from any state, and `reg_reset_o` is high after every edge at which `vin_uv` was high. This takes priority over all other inputs.
- R3: In state 0, with no power cycle pending and no `btn_long`, a 0 on `reg_power_off` moves to state 1. A start made this way enters state 2 on the first edge at which `rails_pgood` is high.
- R4: In state 0, `btn_long` moves to state 1. After a button start the state stays 1 while `btn_held` is high and `rail_fault` is low. With `btn_held` low it moves to 2 if `rails_pgood` is high and to 0 if it is not. With `btn_held` and `rail_fault` both high it moves to 0.
- R5: `pwr_cycle` in state 2, 3 or 4 moves to state 0 for exactly one cycle and then to state 1. After this the state stays 1 until WAIT_MS `ms_tick` pulses have been counted, and moves to 2 on the next edge.
- R6: The sleep request is `sleep_gpio | reg_sleep` when `sleep_mode_or` is 1 and `sleep_gpio & reg_sleep` when it is 0. In state 2 a true request moves to state 3. In state 3 a false request moves back to 2.
- R7: Deep sleep uses the same rule with its own inputs. With the default of no GPIO assigned, `reg_dslp` alone decides and `dslp_gpio` has no effect. Deep sleep wins over sleep when both are requested in state 2.
- R8: `btn_long` in state 3 or 4 moves to state 2 and gives a one-cycle pulse on `clr_sleep_o`.
- R9: `over_temp` in any state other than 0 moves to state 5, which overrides sleep and button requests. In state 5 every rail enable and the reset output are 0. When `over_temp` goes low the state moves directly to 2.
- R10: In state 5 `irq_o` is the inverse of `thermal_mask` as sampled at the previous edge. The mask has no effect on entry into state 5.
- R11: `ser_reset_o` pulses for one cycle on every entry into state 3, 4 or 5.
- R12: All rail enables are 1 in states 1 and 2. States 3 and 4 apply SLEEP_MASK and DSLP_MASK. States 0 and 5 apply 0. `rst_n_o` is 1 only in states 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| btn_long | input | 1 | Pulse: button held past the debounce time |
| btn_held | input | 1 | Level: button currently pressed |
| btn_off | input | 1 | Pulse: button requests power-off |
| pwr_cycle | input | 1 | Pulse: button requests a power cycle |
| reg_power_off | input | 1 | Power-off register bit; 0 requests start |
| reg_sleep | input | 1 | Sleep register bit |
| reg_dslp | input | 1 | Deep-sleep register bit |
| sleep_mode_or | input | 1 | Sleep combine mode: 1 = OR, 0 = AND |
| dslp_mode_or | input | 1 | Deep-sleep combine mode: 1 = OR, 0 = AND |
| sleep_gpio | input | 1 | Sleep GPIO control line |
| dslp_gpio | input | 1 | Deep-sleep GPIO control line |
| vin_uv | input | 1 | Input undervoltage flag |
| over_temp | input | 1 | Over-temperature flag |
| thermal_mask | input | 1 | Masks the thermal interrupt |
| rails_pgood | input | 1 | All regulators in regulation |
| rail_fault | input | 1 | Any regulator fault |
| state_o | output | 3 | Current state code |
| rail_en_o | output | N_RAILS | Regulator enable requests |
| rst_n_o | output | 1 | Active-low system reset |
| reg_reset_o | output | 1 | Register file reset to defaults |
| ser_reset_o | output | 1 | Serial interface transaction reset pulse |
| clr_sleep_o | output | 1 | Pulse: clear sleep and deep-sleep bits |
| irq_o | output | 1 | Thermal interrupt |

## Verification
A wrong state register shows on `state_o`, and in most cases on `rail_en_o` and `rst_n_o`, one cycle after the edge that caused it. Comparing against a reference model on every cycle therefore catches it at once. A wrong start mode or a wrong tick count stays hidden during start-up. It only appears on the edge that should move the design to the active state, which is up to WAIT_MS ticks later. For that reason the power-cycle wait is observed for its full length. Each priority order is exercised with the competing inputs asserted together.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SEQ    = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_DSLP   = 3'd4,
    ST_THERM  = 3'd5
  } pstate_t;

  typedef enum logic [1:0] {
    SM_REG = 2'd0,
    SM_BTN = 2'd1,
    SM_CYC = 2'd2
  } start_mode_t;
endpackage

// File: rtl/psc_entry_req.sv
module psc_entry_req #(
  parameter bit GPIO_USED = 1'b1
) (
  input  logic reg_bit,
  input  logic gpio,
  input  logic mode_or,
  output logic req
);
  generate
    if (GPIO_USED) begin : g_combined
      always_comb req = mode_or ? (gpio | reg_bit) : (gpio & reg_bit);
    end else begin : g_reg_only
      logic unused_inputs;
      always_comb unused_inputs = gpio ^ mode_or;
      always_comb req = reg_bit;
    end
  endgenerate
endmodule

// File: rtl/psc_ms_timer.sv
module psc_ms_timer #(
  parameter int WAIT_MS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(WAIT_MS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_MS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)            cnt_q <= '0;
    else if (tick && !done)     cnt_q <= cnt_q + 1'b1;
  end

  always_comb done = (cnt_q == LIMIT);

  // R5
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (cnt_q <= LIMIT));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import psc_pkg::*;
#(
  parameter int            N_RAILS        = 5,
  parameter int            WAIT_MS        = 500,
  parameter bit            SLEEP_GPIO_USE = 1'b1,
  parameter bit            DSLP_GPIO_USE  = 1'b0,
  parameter logic [N_RAILS-1:0] SLEEP_MASK = 5'b00011,
  parameter logic [N_RAILS-1:0] DSLP_MASK  = 5'b00001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ms_tick,
  input  logic               btn_long,
  input  logic               btn_held,
  input  logic               btn_off,
  input  logic               pwr_cycle,
  input  logic               reg_power_off,
  input  logic               reg_sleep,
  input  logic               reg_dslp,
  input  logic               sleep_mode_or,
  input  logic               dslp_mode_or,
  input  logic               sleep_gpio,
  input  logic               dslp_gpio,
  input  logic               vin_uv,
  input  logic               over_temp,
  input  logic               thermal_mask,
  input  logic               rails_pgood,
  input  logic               rail_fault,
  output logic [2:0]         state_o,
  output logic [N_RAILS-1:0] rail_en_o,
  output logic               rst_n_o,
  output logic               reg_reset_o,
  output logic               ser_reset_o,
  output logic               clr_sleep_o,
  output logic               irq_o
);
  localparam logic [N_RAILS-1:0] ALL_ON = {N_RAILS{1'b1}};

  pstate_t     state_q, nxt;
  start_mode_t mode_q, nxt_mode;
  logic        pend_q, nxt_pend;
  logic        sleep_req, dslp_req, tmr_done, tmr_run;
  logic        in_low_pwr;

  psc_entry_req #(.GPIO_USED(SLEEP_GPIO_USE)) u_sleep_req (
    .reg_bit(reg_sleep), .gpio(sleep_gpio), .mode_or(sleep_mode_or), .req(sleep_req));

  psc_entry_req #(.GPIO_USED(DSLP_GPIO_USE)) u_dslp_req (
    .reg_bit(reg_dslp), .gpio(dslp_gpio), .mode_or(dslp_mode_or), .req(dslp_req));

  always_comb tmr_run = (state_q == ST_SEQ) && (mode_q == SM_CYC);

  psc_ms_timer #(.WAIT_MS(WAIT_MS)) u_timer (
    .clk(clk), .rst(rst), .run(tmr_run), .tick(ms_tick), .done(tmr_done));

  always_comb in_low_pwr = (state_q == ST_SLEEP) || (state_q == ST_DSLP);

  always_comb begin
    nxt      = state_q;
    nxt_mode = mode_q;
    nxt_pend = pend_q;
    if (vin_uv) begin
      nxt      = ST_OFF;
      nxt_pend = 1'b0;
    end else if (over_temp && state_q != ST_OFF) begin
      nxt = ST_THERM;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (pend_q) begin
            nxt = ST_SEQ; nxt_mode = SM_CYC; nxt_pend = 1'b0;
          end else if (btn_long) begin
            nxt = ST_SEQ; nxt_mode = SM_BTN;
          end else if (!reg_power_off) begin
            nxt = ST_SEQ; nxt_mode = SM_REG;
          end
        end
        ST_SEQ: begin
          unique case (mode_q)
            SM_BTN: begin
              if (btn_held && rail_fault) nxt = ST_OFF;
              else if (!btn_held)         nxt = rails_pgood ? ST_ACTIVE : ST_OFF;
            end
            SM_CYC:  if (tmr_done)    nxt = ST_ACTIVE;
            default: if (rails_pgood) nxt = ST_ACTIVE;
          endcase
        end
        ST_ACTIVE, ST_SLEEP, ST_DSLP: begin
          if (btn_off) begin
            nxt = ST_OFF;
          end else if (pwr_cycle) begin
            nxt = ST_OFF; nxt_pend = 1'b1;
          end else if (state_q == ST_ACTIVE) begin
            if (dslp_req)       nxt = ST_DSLP;
            else if (sleep_req) nxt = ST_SLEEP;
          end else if (state_q == ST_SLEEP) begin
            if (btn_long || !sleep_req) nxt = ST_ACTIVE;
          end else begin
            if (btn_long || !dslp_req)  nxt = ST_ACTIVE;
          end
        end
        ST_THERM: if (!over_temp) nxt = ST_ACTIVE;
        default:  nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      mode_q      <= SM_REG;
      pend_q      <= 1'b0;
      rail_en_o   <= '0;
      rst_n_o     <= 1'b0;
      reg_reset_o <= 1'b0;
      ser_reset_o <= 1'b0;
      clr_sleep_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      state_q     <= nxt;
      mode_q      <= nxt_mode;
      pend_q      <= nxt_pend;
      reg_reset_o <= vin_uv;
      rst_n_o     <= (nxt == ST_ACTIVE) || (nxt == ST_SLEEP) || (nxt == ST_DSLP);
      ser_reset_o <= (nxt != state_q) &&
                     ((nxt == ST_SLEEP) || (nxt == ST_DSLP) || (nxt == ST_THERM));
      clr_sleep_o <= btn_long && in_low_pwr;
      irq_o       <= (nxt == ST_THERM) && !thermal_mask;
      unique case (nxt)
        ST_SEQ, ST_ACTIVE: rail_en_o <= ALL_ON;
        ST_SLEEP:          rail_en_o <= SLEEP_MASK;
        ST_DSLP:           rail_en_o <= DSLP_MASK;
        default:           rail_en_o <= '0;
      endcase
    end
  end

  always_comb state_o = state_q;

  // R2
  uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    vin_uv |=> (state_q == ST_OFF));

  // R9
  thermal_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (over_temp && !vin_uv && state_q != ST_OFF) |=> (state_q == ST_THERM));

  // R9
  thermal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_THERM) |-> (rail_en_o == '0 && !rst_n_o));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_THERM) |-> (irq_o == !$past(thermal_mask)));

  // R5
  cycle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEQ && mode_q == SM_CYC && !tmr_done) |=> (state_q != ST_ACTIVE));

  // R11
  ser_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q != $past(state_q)) &&
     (state_q == ST_SLEEP || state_q == ST_DSLP || state_q == ST_THERM)) |-> ser_reset_o);
endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int NR   = 5;
  localparam int WAIT = 500;
  localparam logic [NR-1:0] SMASK = 5'b00011;
  localparam logic [NR-1:0] DMASK = 5'b00001;

  logic clk = 0, rst = 1;
  logic ms_tick = 0, btn_long = 0, btn_held = 0, btn_off = 0, pwr_cycle = 0;
  logic reg_power_off = 1, reg_sleep = 0, reg_dslp = 0;
  logic sleep_mode_or = 0, dslp_mode_or = 0, sleep_gpio = 0, dslp_gpio = 0;
  logic vin_uv = 0, over_temp = 0, thermal_mask = 0, rails_pgood = 0, rail_fault = 0;
  logic [2:0] state_o;
  logic [NR-1:0] rail_en_o;
  logic rst_n_o, reg_reset_o, ser_reset_o, clr_sleep_o, irq_o;

  pwr_seq_ctrl uut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, tdiv = 0;
  string tag = "R1";

  always @(negedge clk) begin
    tdiv = (tdiv == 3) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == 3);
  end

  // reference model
  int m_st = 0, m_mode = 0, m_cnt = 0;
  bit m_pend = 0;
  logic [NR-1:0] e_rail = '0;
  bit e_rstn = 0, e_regrst = 0, e_ser = 0, e_clr = 0, e_irq = 0;

  always @(posedge clk) begin
    int old, nx;
    bit sreq, dreq;
    old = m_st;
    if (rst) begin
      m_st = 0; m_mode = 0; m_cnt = 0; m_pend = 0;
      e_rail = '0; e_rstn = 0; e_regrst = 0; e_ser = 0; e_clr = 0; e_irq = 0;
    end else begin
      sreq = sleep_mode_or ? (sleep_gpio || reg_sleep) : (sleep_gpio && reg_sleep);
      dreq = reg_dslp;
      nx = old;
      if (vin_uv) begin nx = 0; m_pend = 0; end
      else if (over_temp && old != 0) nx = 5;
      else if (old == 0) begin
        if (m_pend) begin nx = 1; m_mode = 2; m_pend = 0; end
        else if (btn_long) begin nx = 1; m_mode = 1; end
        else if (!reg_power_off) begin nx = 1; m_mode = 0; end
      end else if (old == 1) begin
        if (m_mode == 1) begin
          if (btn_held && rail_fault) nx = 0;
          else if (!btn_held) nx = rails_pgood ? 2 : 0;
        end else if (m_mode == 2) begin
          if (m_cnt == WAIT) nx = 2;
        end else if (rails_pgood) nx = 2;
      end else if (old >= 2 && old <= 4) begin
        if (btn_off) nx = 0;
        else if (pwr_cycle) begin nx = 0; m_pend = 1; end
        else if (old == 2) begin
          if (dreq) nx = 4; else if (sreq) nx = 3;
        end else if (old == 3) begin
          if (btn_long || !sreq) nx = 2;
        end else if (btn_long || !dreq) nx = 2;
      end else if (!over_temp) nx = 2;
      // tick counter while waiting in a power-cycle start
      if (old == 1 && m_mode == 2) begin
        if (ms_tick && m_cnt < WAIT) m_cnt++;
      end else m_cnt = 0;
      m_st = nx;
      e_regrst = vin_uv;
      e_rstn = (nx >= 2 && nx <= 4);
      e_ser = (nx != old) && (nx >= 3);
      e_clr = btn_long && (old == 3 || old == 4);
      e_irq = (nx == 5) && !thermal_mask;
      e_rail = (nx == 1 || nx == 2) ? '1 : (nx == 3) ? SMASK : (nx == 4) ? DMASK : '0;
    end
    #5;
    total++;
    if (state_o !== 3'(m_st) || rail_en_o !== e_rail || rst_n_o !== e_rstn ||
        reg_reset_o !== e_regrst || ser_reset_o !== e_ser || clr_sleep_o !== e_clr ||
        irq_o !== e_irq) begin
      bad++;
      $display("FAIL %s cycle %0d: got st=%0d en=%b rn=%b rr=%b sr=%b cl=%b irq=%b exp st=%0d en=%b rn=%b rr=%b sr=%b cl=%b irq=%b",
        tag, cyc, state_o, rail_en_o, rst_n_o, reg_reset_o, ser_reset_o, clr_sleep_o, irq_o,
        m_st, e_rail, e_rstn, e_regrst, e_ser, e_clr, e_irq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: got running, exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic go(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; go(1); s = 0;
  endtask

  initial begin
    go(3);
    chk(state_o == 0 && rail_en_o == 0 && !rst_n_o, "R1", state_o, 0);
    rst = 0; go(2);
    chk(state_o == 0 && !ser_reset_o && !irq_o, "R1", state_o, 0);

    tag = "R3"; reg_power_off = 0; go(1);
    chk(state_o == 1, "R3", state_o, 1);
    chk(rail_en_o == '1 && !rst_n_o, "R12", rail_en_o, 31);
    go(3); rails_pgood = 1; go(1);
    chk(state_o == 2 && rst_n_o, "R3", state_o, 2);
    reg_power_off = 1;

    tag = "R6"; reg_sleep = 1; go(3);
    chk(state_o == 2, "R6", state_o, 2);
    sleep_gpio = 1; go(1);
    chk(state_o == 3 && rail_en_o == SMASK, "R6", rail_en_o, SMASK);
    chk(ser_reset_o, "R11", ser_reset_o, 1);
    go(1); chk(!ser_reset_o, "R11", ser_reset_o, 0);
    reg_sleep = 0; go(1);
    chk(state_o == 2, "R6", state_o, 2);
    sleep_mode_or = 1; go(1);
    chk(state_o == 3, "R6", state_o, 3);
    tag = "R8"; sleep_gpio = 0; btn_long = 1; go(1); btn_long = 0;
    chk(state_o == 2 && clr_sleep_o, "R8", state_o, 2);
    go(2);

    tag = "R7"; dslp_gpio = 1; dslp_mode_or = 1; go(3);
    chk(state_o == 2, "R7", state_o, 2);
    reg_dslp = 1; reg_sleep = 1; go(1);
    chk(state_o == 4 && rail_en_o == DMASK, "R7", state_o, 4);
    dslp_mode_or = 0; dslp_gpio = 0; go(2);
    chk(state_o == 4, "R7", state_o, 4);
    reg_sleep = 0; reg_dslp = 0; go(1);
    chk(state_o == 2, "R7", state_o, 2);

    tag = "R9"; reg_sleep = 1; thermal_mask = 1; over_temp = 1; btn_long = 1; go(1);
    btn_long = 0; reg_sleep = 0;
    chk(state_o == 5 && rail_en_o == 0 && !rst_n_o, "R9", state_o, 5);
    chk(!irq_o, "R10", irq_o, 0);
    thermal_mask = 0; go(2);
    chk(irq_o, "R10", irq_o, 1);
    over_temp = 0; go(1);
    chk(state_o == 2, "R9", state_o, 2);

    tag = "R5"; pwr_cycle = 1; go(1); pwr_cycle = 0;
    chk(state_o == 0, "R5", state_o, 0);
    go(1); chk(state_o == 1, "R5", state_o, 1);
    go(WAIT * 4 - 20);
    chk(state_o == 1, "R5", state_o, 1);
    go(40);
    chk(state_o == 2, "R5", state_o, 2);

    tag = "R4"; btn_off = 1; go(1); btn_off = 0;
    chk(state_o == 0, "R4", state_o, 0);
    rails_pgood = 0; btn_held = 1; btn_long = 1; go(1); btn_long = 0;
    chk(state_o == 1, "R4", state_o, 1);
    go(3); btn_held = 0; go(1);
    chk(state_o == 0, "R4", state_o, 0);
    rails_pgood = 1; btn_held = 1; btn_long = 1; go(1); btn_long = 0;
    go(4); chk(state_o == 1, "R4", state_o, 1);
    btn_held = 0; go(1);
    chk(state_o == 2, "R4", state_o, 2);
    btn_off = 1; go(1); btn_off = 0;
    btn_held = 1; btn_long = 1; go(1); btn_long = 0;
    rail_fault = 1; go(1);
    chk(state_o == 0, "R4", state_o, 0);
    rail_fault = 0; btn_held = 0;

    tag = "R2"; reg_power_off = 0; go(3);
    over_temp = 1; go(2);
    vin_uv = 1; go(1);
    chk(state_o == 0 && reg_reset_o, "R2", state_o, 0);
    over_temp = 0; go(2);
    chk(state_o == 0, "R2", state_o, 0);
    vin_uv = 0; go(1);
    chk(!reg_reset_o, "R2", reg_reset_o, 0);
    go(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule